// File: doc/BRIEF.md
# Dual-Width Integer Execute Stage with Condition Flags

This block is the integer execute stage of a 64-bit pipeline. Each cycle it can accept one operation on two 64-bit operands. The second operand is either a register value or a sign-extended 13-bit immediate. The block computes add, subtract, bitwise AND, OR and XOR, and it can also load a 22-bit value into the upper part of the low word. The result, the destination register number and a write strobe are registered and appear one cycle after the input strobe.

The condition-code word holds two complete sets of negative, zero, overflow and carry flags. One set describes the low 32 bits of the result and the other describes the full 64 bits. The word is written only when the operation asks for flags. For subtract, the carry flags hold a borrow. A load-upper operation that targets register 0 with an immediate of 0 is a no-operation: it raises a nop indication and writes nothing.

Top module: `xu_exec_stage`

## Requirements
- R1: The flag word packs, from bit 0 upward: 32-bit carry, 32-bit overflow, 32-bit zero, 32-bit negative, 64-bit carry, 64-bit overflow, 64-bit zero, 64-bit negative. Reset clears it to 0x00.
- R2: After a flag-setting operation, bit 3 equals result bit 31 and bit 7 equals result bit 63. Bit 2 is set when result bits 31..0 are zero, and bit 6 is set when the whole result is zero.
- R3: Opcode 0 is add. Bits 0 and 4 are the unsigned carry out of the 32-bit and 64-bit sums. Bits 1 and 5 are signed overflow at those widths.
- R4: Opcode 1 is subtract, giving op1 minus op2. Bits 0 and 4 are set when op1 is unsigned-below op2 at 32 and 64 bits (borrow). Bits 1 and 5 are signed overflow of the difference at each width.
- R5: Opcodes 2, 3 and 4 are AND, OR and XOR. When flags are requested for them, bits 0, 1, 4 and 5 are cleared.
- R6: The flag word keeps its value when set_flags is low, when in_valid is low, and for load-upper operations and unused opcodes.
- R7: When use_imm is 1, src_b is ignored and the second operand is imm13 sign-extended to 64 bits.
- R8: Opcode 5 is load-upper. The result has imm22 in bits 31..10 and zeros in every other bit.
- R9: A load-upper with dest_reg 0 and imm22 0 drives out_nop to 1 and out_wr_en to 0. Any other load-upper drives out_nop to 0 and out_wr_en to 1.
- R10: out_result, out_dest, out_wr_en, out_nop and the flag update appear on the clock edge after in_valid. out_valid and out_wr_en are 0 in any cycle that did not follow an in_valid.
- R11: Opcodes 6 and 7 do not write: out_wr_en stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | Operation code |
| set_flags | input | 1 | Update the flag word with this operation |
| use_imm | input | 1 | Take the second operand from imm13 |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second register operand |
| imm13 | input | 13 | Signed immediate |
| imm22 | input | 22 | Load-upper immediate |
| dest_reg | input | 5 | Destination register number |
| out_valid | output | 1 | Registered outputs belong to an operation |
| out_result | output | 64 | Registered result |
| out_dest | output | 5 | Registered destination number |
| out_wr_en | output | 1 | Destination write strobe |
| out_nop | output | 1 | Operation was a no-operation |
| flags | output | 8 | Condition-code word |

## Verification
The assertions check several relations on every cycle:
- the flag word holds when no update is requested;
- the negative flags track result bits 31 and 63;
- logical operations clear the carry and overflow bits;
- a nop never writes, and every write is marked valid;
- a load-upper keeps its high word zero;
- an immediate operand is a proper sign extension.

The exact carry, borrow and overflow values at both widths, and the zero flags at the 32/64 boundary, can only be shown by the bench. It compares each vector against its own arithmetic model. Its directed scenarios cover the nop case, the unused opcodes and the ignored register operand.

// File: rtl/xu_pkg.sv
package xu_pkg;

  typedef enum logic [2:0] {
    XU_ADD = 3'd0,
    XU_SUB = 3'd1,
    XU_AND = 3'd2,
    XU_OR  = 3'd3,
    XU_XOR = 3'd4,
    XU_LUI = 3'd5
  } xu_op_e;

  localparam int XU_FLAG_W  = 8;
  localparam int XU_LANES   = 2;
  localparam int XU_LANE_FL = 4;

  // carry out of the top bit, recovered from operand and result sign bits
  function automatic logic top_carry(input logic a_msb, input logic b_msb, input logic r_msb);
    top_carry = (a_msb & b_msb) | ((a_msb | b_msb) & ~r_msb);
  endfunction

  // two same-signed addends yielding a result of the other sign
  function automatic logic top_overflow(input logic a_msb, input logic b_msb, input logic r_msb);
    top_overflow = (a_msb == b_msb) && (r_msb != a_msb);
  endfunction

endpackage

// File: rtl/xu_operand_sel.sv
module xu_operand_sel #(
  parameter int DATA_W  = 64,
  parameter int IMM_W   = 13,
  parameter int UIMM_W  = 22,
  parameter int UIMM_SH = 10
) (
  input  logic              use_imm,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  imm13,
  input  logic [UIMM_W-1:0] imm22,
  output logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] lui_val
);
  localparam int EXT_W = DATA_W - IMM_W;
  localparam int PAD_W = DATA_W - UIMM_W - UIMM_SH;

  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    imm_ext = {{EXT_W{imm13[IMM_W-1]}}, imm13};
    op_b    = use_imm ? imm_ext : src_b;
    lui_val = {{PAD_W{1'b0}}, imm22, {UIMM_SH{1'b0}}};
  end

  // R7: an immediate operand carries one sign value through its upper bits
  always_comb begin
    if (use_imm) begin
      a_imm_sext_r7: assert ((op_b[DATA_W-1:IMM_W-1] == '0) || (op_b[DATA_W-1:IMM_W-1] == '1));
    end
  end

endmodule

// File: rtl/xu_alu.sv
module xu_alu
  import xu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] lui_val,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] adder_b,
  output logic              is_arith,
  output logic              is_sub,
  output logic              is_logic,
  output logic              is_lui,
  output logic              op_known
);
  function automatic logic [DATA_W-1:0] add_cin(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y,
                                                 input logic cin);
    add_cin = x + y + {{(DATA_W-1){1'b0}}, cin};
  endfunction

  xu_op_e opc;

  always_comb begin
    opc      = xu_op_e'(op);
    is_sub   = (opc == XU_SUB);
    is_arith = (opc == XU_ADD) || (opc == XU_SUB);
    is_logic = (opc == XU_AND) || (opc == XU_OR) || (opc == XU_XOR);
    is_lui   = (opc == XU_LUI);
    op_known = is_arith || is_logic || is_lui;
    adder_b  = is_sub ? ~b : b;
    unique case (opc)
      XU_ADD, XU_SUB: result = add_cin(a, adder_b, is_sub);
      XU_AND:         result = a & b;
      XU_OR:          result = a | b;
      XU_XOR:         result = a ^ b;
      XU_LUI:         result = lui_val;
      default:        result = '0;
    endcase
  end

endmodule

// File: rtl/xu_flag_lane.sv
module xu_flag_lane
  import xu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] adder_b,
  input  logic [W-1:0] result,
  input  logic         arith,
  input  logic         sub,
  output logic         c,
  output logic         v,
  output logic         z,
  output logic         n
);
  logic raw_carry;

  always_comb begin
    raw_carry = top_carry(a[W-1], adder_b[W-1], result[W-1]);
    c = arith ? (sub ? ~raw_carry : raw_carry) : 1'b0;
    v = arith ? top_overflow(a[W-1], adder_b[W-1], result[W-1]) : 1'b0;
    z = (result == '0);
    n = result[W-1];
  end

endmodule

// File: rtl/xu_flag_unit.sv
module xu_flag_unit
  import xu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LO_W   = 32
) (
  input  logic [DATA_W-1:0]    a,
  input  logic [DATA_W-1:0]    adder_b,
  input  logic [DATA_W-1:0]    result,
  input  logic                 arith,
  input  logic                 sub,
  output logic [XU_FLAG_W-1:0] flag_word
);
  logic [XU_LANES-1:0] c_l, v_l, z_l, n_l;

  for (genvar g = 0; g < XU_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? LO_W : DATA_W;
    xu_flag_lane #(.W(LW)) u_lane (
      .a       (a[LW-1:0]),
      .adder_b (adder_b[LW-1:0]),
      .result  (result[LW-1:0]),
      .arith   (arith),
      .sub     (sub),
      .c       (c_l[g]),
      .v       (v_l[g]),
      .z       (z_l[g]),
      .n       (n_l[g])
    );
    // R1: each lane occupies one nibble, carry lowest, negative highest
    assign flag_word[g*XU_LANE_FL +: XU_LANE_FL] = {n_l[g], z_l[g], v_l[g], c_l[g]};
  end

endmodule

// File: rtl/xu_exec_stage.sv
module xu_exec_stage
  import xu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int LO_W    = 32,
  parameter int IMM_W   = 13,
  parameter int UIMM_W  = 22,
  parameter int UIMM_SH = 10,
  parameter int REG_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [2:0]           op,
  input  logic                 set_flags,
  input  logic                 use_imm,
  input  logic [DATA_W-1:0]    src_a,
  input  logic [DATA_W-1:0]    src_b,
  input  logic [IMM_W-1:0]     imm13,
  input  logic [UIMM_W-1:0]    imm22,
  input  logic [REG_W-1:0]     dest_reg,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_result,
  output logic [REG_W-1:0]     out_dest,
  output logic                 out_wr_en,
  output logic                 out_nop,
  output logic [XU_FLAG_W-1:0] flags
);
  logic [DATA_W-1:0]    op_b, lui_val, alu_res, adder_b;
  logic                 is_arith, is_sub, is_logic, is_lui, op_known;
  logic [XU_FLAG_W-1:0] flag_next;
  logic                 lui_nop, flag_we, wr_next;

  xu_operand_sel #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .UIMM_W(UIMM_W), .UIMM_SH(UIMM_SH)
  ) u_opsel (
    .use_imm (use_imm),
    .src_b   (src_b),
    .imm13   (imm13),
    .imm22   (imm22),
    .op_b    (op_b),
    .lui_val (lui_val)
  );

  xu_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op),
    .a        (src_a),
    .b        (op_b),
    .lui_val  (lui_val),
    .result   (alu_res),
    .adder_b  (adder_b),
    .is_arith (is_arith),
    .is_sub   (is_sub),
    .is_logic (is_logic),
    .is_lui   (is_lui),
    .op_known (op_known)
  );

  xu_flag_unit #(.DATA_W(DATA_W), .LO_W(LO_W)) u_flags (
    .a         (src_a),
    .adder_b   (adder_b),
    .result    (alu_res),
    .arith     (is_arith),
    .sub       (is_sub),
    .flag_word (flag_next)
  );

  always_comb begin
    lui_nop = in_valid && is_lui && (dest_reg == '0) && (imm22 == '0);
    flag_we = in_valid && set_flags && (is_arith || is_logic);
    wr_next = in_valid && op_known && !lui_nop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_dest   <= '0;
      out_wr_en  <= 1'b0;
      out_nop    <= 1'b0;
      flags      <= '0;
    end else begin
      out_valid <= in_valid;
      out_wr_en <= wr_next;
      out_nop   <= lui_nop;
      if (in_valid) begin
        out_result <= alu_res;
        out_dest   <= dest_reg;
      end
      if (flag_we) flags <= flag_next;
    end
  end

  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));

  p_neg_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags[7] == out_result[DATA_W-1]) && (flags[3] == out_result[LO_W-1]));

  p_zero_nest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flags[6] |-> flags[2]);

  p_logic_cv_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && is_logic) |=> (flags[5:4] == 2'b00) && (flags[1:0] == 2'b00));

  p_nop_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_nop |-> !out_wr_en);

  p_write_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_en |-> out_valid);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_lui_high_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_lui) |=> (out_result[DATA_W-1:LO_W] == '0));

  p_unknown_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_known) |=> !out_wr_en);

endmodule

// File: tb/xu_exec_stage_tb.sv
`timescale 1ns/1ps
module xu_exec_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic        set_flags = 1'b0;
  logic        use_imm = 1'b0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [12:0] imm13 = '0;
  logic [21:0] imm22 = '0;
  logic [4:0]  dest_reg = '0;
  logic        out_valid, out_wr_en, out_nop;
  logic [63:0] out_result;
  logic [4:0]  out_dest;
  logic [7:0]  flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [7:0] exp_flags = '0;

  always #10 clk = ~clk;

  xu_exec_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .set_flags(set_flags),
    .use_imm(use_imm), .src_a(src_a), .src_b(src_b), .imm13(imm13), .imm22(imm22),
    .dest_reg(dest_reg), .out_valid(out_valid), .out_result(out_result),
    .out_dest(out_dest), .out_wr_en(out_wr_en), .out_nop(out_nop), .flags(flags)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        imm;
    logic        set;
    logic [63:0] a;
    logic [63:0] b;
    logic [12:0] i13;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'd0, 1'b0, 1'b1, 64'd1, 64'd2, 13'd0},
    '{3'd0, 1'b0, 1'b1, 64'h0000_0000_7FFF_FFFF, 64'd1, 13'd0},
    '{3'd0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 13'd0},
    '{3'd0, 1'b0, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'd1, 13'd0},
    '{3'd0, 1'b0, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_0000_0001, 13'd0},
    '{3'd1, 1'b0, 1'b1, 64'd5, 64'd5, 13'd0},
    '{3'd1, 1'b0, 1'b1, 64'd0, 64'd1, 13'd0},
    '{3'd1, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'd1, 13'd0},
    '{3'd1, 1'b0, 1'b1, 64'h0000_0001_8000_0000, 64'h0000_0000_8000_0001, 13'd0},
    '{3'd2, 1'b0, 1'b1, 64'hF0F0_0000_FFFF_0000, 64'hFFFF_FFFF_0000_FFFF, 13'd0},
    '{3'd3, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_8000_0000, 13'd0},
    '{3'd4, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 13'd0},
    '{3'd0, 1'b1, 1'b1, 64'd5, 64'hDEAD_BEEF_DEAD_BEEF, 13'h1FFF},
    '{3'd1, 1'b0, 1'b0, 64'd3, 64'd7, 13'd0}
  };

  // independent model: wide sums for carry, sign-extended sums for overflow
  function automatic logic [71:0] model(input vec_t v, input logic [7:0] old);
    logic [63:0] b, r;
    logic [64:0] s65, t65;
    logic [32:0] s33, t33;
    logic c32, v32, c64, v64;
    b = v.imm ? 64'($signed(v.i13)) : v.b;
    c32 = 0; v32 = 0; c64 = 0; v64 = 0;
    case (v.op)
      3'd0: begin
        r = v.a + b;
        s65 = {1'b0, v.a} + {1'b0, b};               c64 = s65[64];
        s33 = {1'b0, v.a[31:0]} + {1'b0, b[31:0]};   c32 = s33[32];
        t65 = {v.a[63], v.a} + {b[63], b};           v64 = t65[64] ^ t65[63];
        t33 = {v.a[31], v.a[31:0]} + {b[31], b[31:0]}; v32 = t33[32] ^ t33[31];
      end
      3'd1: begin
        r = v.a - b;
        c64 = v.a < b;
        c32 = v.a[31:0] < b[31:0];
        t65 = {v.a[63], v.a} - {b[63], b};           v64 = t65[64] ^ t65[63];
        t33 = {v.a[31], v.a[31:0]} - {b[31], b[31:0]}; v32 = t33[32] ^ t33[31];
      end
      3'd2: r = v.a & b;
      3'd3: r = v.a | b;
      default: r = v.a ^ b;
    endcase
    if (v.set)
      model = {r, r[63], (r == 0), v64, c64, r[31], (r[31:0] == 0), v32, c32};
    else
      model = {r, old};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic im, input logic sf,
                       input logic [63:0] a, input logic [63:0] b, input logic [12:0] i13,
                       input logic [21:0] i22, input logic [4:0] rd);
    @(negedge clk);
    op = o; use_imm = im; set_flags = sf; src_a = a; src_b = b;
    imm13 = i13; imm22 = i22; dest_reg = rd; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 R10: reset state
    check("R1 reset flags", 64'(flags), 64'h00);
    check("R10 reset valid", 64'(out_valid), 64'd0);
    check("R10 reset wr_en", 64'(out_wr_en), 64'd0);
    rst_n = 1'b1;

    // R1 R3: 0x7FFFFFFF + 1 gives 32-bit negative and overflow only
    issue(3'd0, 0, 1, 64'h7FFF_FFFF, 64'd1, 13'd0, 22'd0, 5'd3);
    check("R1 R3 packing", 64'(flags), 64'h0A);
    exp_flags = flags;
    // R4: 0 - 1 borrows at both widths
    issue(3'd1, 0, 1, 64'd0, 64'd1, 13'd0, 22'd0, 5'd3);
    check("R4 borrow", 64'(flags), 64'h99);
    check("R4 result", out_result, 64'hFFFF_FFFF_FFFF_FFFF);
    exp_flags = 8'h99;

    for (int i = 0; i < NV; i++) begin
      logic [71:0] m;
      m = model(VECS[i], exp_flags);
      issue(VECS[i].op, VECS[i].imm, VECS[i].set, VECS[i].a, VECS[i].b, VECS[i].i13, 22'd0, 5'd7);
      check("R2 R3 R4 R5 R7 result", out_result, m[71:8]);
      check("R1 R2 R3 R4 R5 R6 flags", 64'(flags), 64'(m[7:0]));
      check("R10 wr_en", 64'(out_wr_en), 64'd1);
      exp_flags = m[7:0];
    end

    // R7: register operand ignored under immediate select
    issue(3'd3, 1, 0, 64'd0, 64'hFFFF_0000_FFFF_0000, 13'h0010, 22'd0, 5'd1);
    check("R7 imm ignores src_b", out_result, 64'h10);

    // R8 R6: load-upper places field, leaves flags alone even with set_flags
    issue(3'd5, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 13'h1FFF, 22'h3FFFFF, 5'd9);
    check("R8 lui result", out_result, 64'h0000_0000_FFFF_FC00);
    check("R6 lui flags", 64'(flags), 64'(exp_flags));
    check("R9 lui writes", 64'(out_wr_en), 64'd1);
    check("R9 lui not nop", 64'(out_nop), 64'd0);
    check("R10 dest", 64'(out_dest), 64'd9);

    // R9: nop form
    issue(3'd5, 0, 0, 64'd0, 64'd0, 13'd0, 22'd0, 5'd0);
    check("R9 nop flag", 64'(out_nop), 64'd1);
    check("R9 nop no write", 64'(out_wr_en), 64'd0);
    // R9: register 0 with nonzero field still writes
    issue(3'd5, 0, 0, 64'd0, 64'd0, 13'd0, 22'd1, 5'd0);
    check("R9 rd0 nonzero", 64'(out_wr_en), 64'd1);
    check("R8 small lui", out_result, 64'h400);

    // R11: unused opcodes
    issue(3'd6, 0, 1, 64'd1, 64'd1, 13'd0, 22'd0, 5'd4);
    check("R11 op6 wr_en", 64'(out_wr_en), 64'd0);
    check("R6 op6 flags", 64'(flags), 64'(exp_flags));
    issue(3'd7, 0, 1, 64'd1, 64'd1, 13'd0, 22'd0, 5'd4);
    check("R11 op7 wr_en", 64'(out_wr_en), 64'd0);

    // R10 R6: idle cycle with set_flags high but no in_valid
    @(negedge clk);
    set_flags = 1'b1; op = 3'd0; src_a = '0; src_b = '0;
    @(negedge clk);
    check("R10 idle valid", 64'(out_valid), 64'd0);
    check("R10 idle wr_en", 64'(out_wr_en), 64'd0);
    check("R6 idle flags", 64'(flags), 64'(exp_flags));

    finish_run();
  end

endmodule